// File: doc/BRIEF.md
# Privilege-Gated Cycle Timestamp Counter

This block keeps a free-running cycle count that starts at zero when reset is released and advances on every clock edge. The count can be read through two request paths. The timestamp path returns the count split into an upper and a lower half. The privileged path returns the whole count as one word. Each request is checked against a timestamp-disable control, the current privilege level (0 is the most privileged) and the execution mode. A request that fails the check raises a general-protection fault pulse and returns no data.

The execution mode is a 2-bit code: 00 selects real-address mode, 01 protected mode and 10 virtual-8086 mode. The code 11 is treated as protected mode. All inputs are sampled on the clock edge that sees the request. The response appears during the following cycle. A fault also reports whether it carries an error code. The error code itself is always zero.

Top module: `cyc_stamp_unit`

## Requirements
- R1: The internal count rises by exactly one on every clock edge while reset is inactive. It keeps counting through reads and faults. It wraps from all ones to zero with no overflow indication.
- R2: While rst_ni is low, the count is zero, every valid and fault output is low, and every data output is zero.
- R3: When the timestamp path is granted, rd_valid_o is high for the one cycle after the request edge. rd_hi_o and rd_lo_o then hold the upper and lower halves of a single count value, the one held during the request cycle.
- R4: If tsd_i is 0, a timestamp request is granted for every privilege level 0 to 3 and every mode code.
- R5: If tsd_i is 1 and the mode is 01 or 11, a timestamp request is granted only at privilege 0. At privilege 1, 2 or 3 it faults with fault_code_vld_o = 1.
- R6: If tsd_i is 1 and the mode is 00 (real), a timestamp request faults at every privilege level with fault_code_vld_o = 0.
- R7: If tsd_i is 1 and the mode is 10 (virtual-8086), a timestamp request faults at every privilege level with fault_code_vld_o = 1.
- R8: A privileged-path request is granted only at privilege 0, whatever tsd_i is. It then pulses msr_valid_o and puts the whole count from the request cycle on msr_data_o. At any other privilege level it faults, with fault_code_vld_o = 1 unless the mode is 00.
- R9: If both paths request in the same cycle, the privileged path is served and the timestamp request is ignored. rd_valid_o stays low and rd_hi_o and rd_lo_o keep their values.
- R10: fault_o is a one-cycle pulse per faulting request and never coincides with a valid pulse. During a fault, all data outputs keep their previous values, and fault_code_vld_o is 0 whenever fault_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Timestamp read request strobe |
| msr_req_i | input | 1 | Privileged full-width read request strobe |
| priv_i | input | 2 | Current privilege level, 0 most privileged |
| mode_i | input | 2 | Execution mode: 00 real, 01 protected, 10 virtual-8086, 11 as protected |
| tsd_i | input | 1 | Timestamp-disable control |
| rd_valid_o | output | 1 | Timestamp read response pulse |
| rd_hi_o | output | HALF_W | Upper half of the sampled count |
| rd_lo_o | output | HALF_W | Lower half of the sampled count |
| msr_valid_o | output | 1 | Privileged read response pulse |
| msr_data_o | output | 2*HALF_W | Full sampled count |
| fault_o | output | 1 | General-protection fault pulse |
| fault_code_vld_o | output | 1 | Fault carries an error code (value zero) |

## Verification
The bench sweeps the full grid of disable flag, privilege level and mode code, and mixes in random requests. A design that treated real mode like protected mode would grant privilege 0 instead of faulting. A design that flagged an error code in real mode would be caught on fault_code_vld_o. Requests on both paths in the same cycle expose a design that answers the timestamp path too, or that overwrites the halves. Back-to-back faults check that the data outputs are not overwritten. A narrow second instance is read across its all-ones to zero step, which catches a counter that saturates or raises a flag instead of wrapping. Reset applied in the middle of a run must bring later readings back near zero.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_V86  = 2'b10,
    MODE_RSVD = 2'b11
  } exec_mode_e;

  typedef struct packed {
    logic grant;
    logic fault;
    logic code_vld;
  } access_res_t;

  localparam access_res_t RES_IDLE = '{grant: 1'b0, fault: 1'b0, code_vld: 1'b0};

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // wraps silently by truncation
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + STEP;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tsc_access_chk.sv
module tsc_access_chk
  import tsc_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              rd_req_i,
  input  logic              msr_req_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic [1:0]        mode_i,
  input  logic              tsd_i,
  output access_res_t       rd_res_o,
  output access_res_t       msr_res_o
);

  exec_mode_e mode;
  logic       ring0;
  logic       rd_eff;
  logic       rd_allow;
  logic       rd_code;

  assign mode   = exec_mode_e'(mode_i);
  assign ring0  = (priv_i == '0);
  assign rd_eff = rd_req_i & ~msr_req_i;  // privileged path wins

  always_comb begin
    rd_allow = 1'b1;
    rd_code  = 1'b1;
    if (tsd_i) begin
      unique case (mode)
        MODE_REAL: begin
          rd_allow = 1'b0;
          rd_code  = 1'b0;
        end
        MODE_V86:  rd_allow = 1'b0;
        MODE_PROT,
        MODE_RSVD: rd_allow = ring0;
        default:   rd_allow = 1'b0;
      endcase
    end
  end

  always_comb begin
    rd_res_o = RES_IDLE;
    if (rd_eff) begin
      rd_res_o.grant    = rd_allow;
      rd_res_o.fault    = ~rd_allow;
      rd_res_o.code_vld = ~rd_allow & rd_code;
    end
  end

  always_comb begin
    msr_res_o = RES_IDLE;
    if (msr_req_i) begin
      msr_res_o.grant    = ring0;
      msr_res_o.fault    = ~ring0;
      msr_res_o.code_vld = ~ring0 & (mode != MODE_REAL);
    end
  end

endmodule

// File: rtl/tsc_read_port.sv
module tsc_read_port
  import tsc_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W,
  localparam int NPART = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  access_res_t       rd_res_i,
  input  access_res_t       msr_res_i,
  output logic              rd_valid_o,
  output logic [HALF_W-1:0] rd_hi_o,
  output logic [HALF_W-1:0] rd_lo_o,
  output logic              msr_valid_o,
  output logic [CNT_W-1:0]  msr_data_o,
  output logic              fault_o,
  output logic              fault_code_vld_o
);

  logic [NPART-1:0][HALF_W-1:0] part_q;
  logic [CNT_W-1:0]             full_q;
  logic                         rd_vld_q, msr_vld_q, flt_q, code_q;

  // half-word registers, both loaded from one sample
  for (genvar p = 0; p < NPART; p++) begin : g_part
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             part_q[p] <= '0;
      else if (rd_res_i.grant) part_q[p] <= cnt_i[p*HALF_W +: HALF_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              full_q <= '0;
    else if (msr_res_i.grant) full_q <= cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_q  <= 1'b0;
      msr_vld_q <= 1'b0;
      flt_q     <= 1'b0;
      code_q    <= 1'b0;
    end else begin
      rd_vld_q  <= rd_res_i.grant;
      msr_vld_q <= msr_res_i.grant;
      flt_q     <= rd_res_i.fault | msr_res_i.fault;
      code_q    <= msr_res_i.fault ? msr_res_i.code_vld : rd_res_i.code_vld;
    end
  end

  assign rd_valid_o       = rd_vld_q;
  assign rd_lo_o          = part_q[0];
  assign rd_hi_o          = part_q[NPART-1];
  assign msr_valid_o      = msr_vld_q;
  assign msr_data_o       = full_q;
  assign fault_o          = flt_q;
  assign fault_code_vld_o = code_q;

endmodule

// File: rtl/cyc_stamp_unit.sv
module cyc_stamp_unit
  import tsc_pkg::*;
#(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              msr_req_i,
  input  logic [1:0]        priv_i,
  input  logic [1:0]        mode_i,
  input  logic              tsd_i,
  output logic              rd_valid_o,
  output logic [HALF_W-1:0] rd_hi_o,
  output logic [HALF_W-1:0] rd_lo_o,
  output logic              msr_valid_o,
  output logic [CNT_W-1:0]  msr_data_o,
  output logic              fault_o,
  output logic              fault_code_vld_o
);

  logic [CNT_W-1:0] cnt;
  access_res_t      rd_res;
  access_res_t      msr_res;

  tsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt)
  );

  tsc_access_chk #(.PRIV_W(2)) u_chk_acc (
    .rd_req_i  (rd_req_i),
    .msr_req_i (msr_req_i),
    .priv_i    (priv_i),
    .mode_i    (mode_i),
    .tsd_i     (tsd_i),
    .rd_res_o  (rd_res),
    .msr_res_o (msr_res)
  );

  tsc_read_port #(.HALF_W(HALF_W)) u_port (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .cnt_i            (cnt),
    .rd_res_i         (rd_res),
    .msr_res_i        (msr_res),
    .rd_valid_o       (rd_valid_o),
    .rd_hi_o          (rd_hi_o),
    .rd_lo_o          (rd_lo_o),
    .msr_valid_o      (msr_valid_o),
    .msr_data_o       (msr_data_o),
    .fault_o          (fault_o),
    .fault_code_vld_o (fault_code_vld_o)
  );

endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_i,
  input logic              msr_req_i,
  input logic [1:0]        priv_i,
  input logic [1:0]        mode_i,
  input logic              tsd_i,
  input logic              rd_valid_o,
  input logic [HALF_W-1:0] rd_hi_o,
  input logic [HALF_W-1:0] rd_lo_o,
  input logic              msr_valid_o,
  input logic [CNT_W-1:0]  msr_data_o,
  input logic              fault_o,
  input logic              fault_code_vld_o,
  input logic [CNT_W-1:0]  cnt_i
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_i == $past(cnt_i) + ONE));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r2_reset_clear: assert (cnt_i == '0 && !rd_valid_o && !msr_valid_o && !fault_o
                                && rd_hi_o == '0 && rd_lo_o == '0 && msr_data_o == '0);
    end
  end

  a_r3_same_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ({rd_hi_o, rd_lo_o} == $past(cnt_i)));

  a_r4_tsd_clear_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !msr_req_i && !tsd_i) |=> rd_valid_o);

  a_r5_prot_ring_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !msr_req_i && tsd_i && mode_i[0] && priv_i != 2'd0)
      |=> (fault_o && fault_code_vld_o));

  a_r6_real_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !msr_req_i && tsd_i && mode_i == 2'b00) |=> (fault_o && !fault_code_vld_o));

  a_r7_v86_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !msr_req_i && tsd_i && mode_i == 2'b10) |=> (fault_o && fault_code_vld_o));

  a_r8_msr_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_valid_o |-> (msr_data_o == $past(cnt_i)));

  a_r8_msr_priv_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_req_i && priv_i != 2'd0) |=> fault_o);

  a_r9_msr_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_req_i |=> (!rd_valid_o && $stable(rd_hi_o) && $stable(rd_lo_o)));

  a_r10_fault_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!rd_valid_o && !msr_valid_o));

  a_r10_fault_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($stable(rd_hi_o) && $stable(rd_lo_o) && $stable(msr_data_o)));

  a_r10_code_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> !fault_code_vld_o);

endmodule

bind cyc_stamp_unit tsc_chk #(.HALF_W(HALF_W)) u_tsc_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .rd_req_i         (rd_req_i),
  .msr_req_i        (msr_req_i),
  .priv_i           (priv_i),
  .mode_i           (mode_i),
  .tsd_i            (tsd_i),
  .rd_valid_o       (rd_valid_o),
  .rd_hi_o          (rd_hi_o),
  .rd_lo_o          (rd_lo_o),
  .msr_valid_o      (msr_valid_o),
  .msr_data_o       (msr_data_o),
  .fault_o          (fault_o),
  .fault_code_vld_o (fault_code_vld_o),
  .cnt_i            (cnt)
);

// File: tb/cyc_stamp_unit_tb_top.sv
`timescale 1ns/1ps
module cyc_stamp_unit_tb_top;

  localparam int HW  = 32;
  localparam int CW  = 2 * HW;
  localparam int SHW = 4;
  localparam int SCW = 2 * SHW;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic rd_req = 1'b0, msr_req = 1'b0, tsd = 1'b0;
  logic [1:0] priv = '0, mode = '0;

  logic          rd_v, msr_v, flt, code;
  logic [HW-1:0] hi, lo;
  logic [CW-1:0] md;
  logic           w_rd_v, w_msr_v, w_flt, w_code;
  logic [SHW-1:0] w_hi, w_lo;
  logic [SCW-1:0] w_md;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [CW-1:0] tb_cnt;

  always #4 clk = ~clk;

  cyc_stamp_unit #(.HALF_W(HW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .msr_req_i(msr_req),
    .priv_i(priv), .mode_i(mode), .tsd_i(tsd),
    .rd_valid_o(rd_v), .rd_hi_o(hi), .rd_lo_o(lo), .msr_valid_o(msr_v),
    .msr_data_o(md), .fault_o(flt), .fault_code_vld_o(code));

  // narrow instance to reach the wrap point quickly
  cyc_stamp_unit #(.HALF_W(SHW)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .msr_req_i(msr_req),
    .priv_i(priv), .mode_i(mode), .tsd_i(tsd),
    .rd_valid_o(w_rd_v), .rd_hi_o(w_hi), .rd_lo_o(w_lo), .msr_valid_o(w_msr_v),
    .msr_data_o(w_md), .fault_o(w_flt), .fault_code_vld_o(w_code));

  // reference count: edges seen since reset release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_cnt <= '0;
    else        tb_cnt <= tb_cnt + 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic void expect_resp(input logic r, input logic m, input logic [1:0] p,
                                      input logic [1:0] md_c, input logic t,
                                      output logic e_rd, output logic e_msr,
                                      output logic e_flt, output logic e_code);
    e_rd = 0; e_msr = 0; e_flt = 0; e_code = 0;
    if (m) begin
      if (p == 2'd0) e_msr = 1;
      else begin e_flt = 1; e_code = (md_c != 2'b00); end
    end else if (r) begin
      if (!t) e_rd = 1;
      else if (md_c == 2'b00) begin e_flt = 1; e_code = 0; end
      else if (md_c == 2'b10) begin e_flt = 1; e_code = 1; end
      else if (p == 2'd0) e_rd = 1;
      else begin e_flt = 1; e_code = 1; end
    end
  endfunction

  // called at a falling edge; returns at the next falling edge with outputs checked
  task automatic do_req(input logic r, input logic m, input logic [1:0] p,
                        input logic [1:0] md_c, input logic t, input string req);
    logic [CW-1:0]  exp_cnt, p_md, e_full, e_md;
    logic [SCW-1:0] p_wfull, p_wmd, e_wfull, e_wmd;
    logic e_rd, e_msr, e_flt, e_code;
    bit ok;
    rd_req = r; msr_req = m; priv = p; mode = md_c; tsd = t;
    exp_cnt = tb_cnt;
    p_md = md; p_wfull = {w_hi, w_lo}; p_wmd = w_md;
    e_full = {hi, lo};
    expect_resp(r, m, p, md_c, t, e_rd, e_msr, e_flt, e_code);
    if (e_rd) begin e_full = exp_cnt; e_wfull = exp_cnt[SCW-1:0]; end
    else e_wfull = p_wfull;
    e_md  = e_msr ? exp_cnt : p_md;
    e_wmd = e_msr ? exp_cnt[SCW-1:0] : p_wmd;
    @(negedge clk);
    ok = (rd_v == e_rd) && (msr_v == e_msr) && (flt == e_flt) && (code == e_code)
         && ({hi, lo} == e_full) && (md == e_md);
    check(ok, req, $sformatf(
      "r=%0b m=%0b p=%0d mode=%0d tsd=%0b act v=%0b mv=%0b f=%0b c=%0b d=%h md=%h exp v=%0b mv=%0b f=%0b c=%0b d=%h md=%h",
      r, m, p, md_c, t, rd_v, msr_v, flt, code, {hi, lo}, md,
      e_rd, e_msr, e_flt, e_code, e_full, e_md));
    check(({w_hi, w_lo} == e_wfull) && (w_md == e_wmd) && (w_rd_v == e_rd) && (w_flt == e_flt),
          "R1", $sformatf("narrow act d=%h md=%h exp d=%h md=%h", {w_hi, w_lo}, w_md, e_wfull, e_wmd));
    rd_req = 0; msr_req = 0;
  endtask

  task automatic check_reset(input string req);
    check(!rd_v && !msr_v && !flt && !code && hi == '0 && lo == '0 && md == '0
          && !w_rd_v && !w_flt && w_md == '0 && {w_hi, w_lo} == '0, req,
          $sformatf("act v=%0b mv=%0b f=%0b d=%h md=%h exp all zero", rd_v, msr_v, flt, {hi, lo}, md));
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [CW-1:0] first;
    int unused;
    unused = $urandom(32'h5eed_7a11);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset("R2");
    rst_n = 1'b1;
    @(negedge clk);

    // R4: disable clear, every mode and level
    for (int mi = 0; mi < 4; mi++)
      for (int pi = 0; pi < 4; pi++)
        do_req(1, 0, 2'(pi), 2'(mi), 0, "R4");
    // R5: protected and reserved code with disable set
    for (int pi = 0; pi < 4; pi++) do_req(1, 0, 2'(pi), 2'b01, 1, "R5");
    for (int pi = 0; pi < 4; pi++) do_req(1, 0, 2'(pi), 2'b11, 1, "R5");
    // R6: real mode
    for (int pi = 0; pi < 4; pi++) do_req(1, 0, 2'(pi), 2'b00, 1, "R6");
    // R7: virtual-8086
    for (int pi = 0; pi < 4; pi++) do_req(1, 0, 2'(pi), 2'b10, 1, "R7");
    // R8: privileged path
    do_req(0, 1, 2'd0, 2'b01, 1, "R8");
    do_req(0, 1, 2'd0, 2'b00, 0, "R8");
    do_req(0, 1, 2'd3, 2'b01, 0, "R8");
    do_req(0, 1, 2'd2, 2'b00, 1, "R8");
    do_req(0, 1, 2'd1, 2'b10, 0, "R8");
    // R9: both paths together
    do_req(1, 0, 2'd0, 2'b01, 0, "R3");
    do_req(1, 1, 2'd0, 2'b01, 0, "R9");
    do_req(1, 1, 2'd3, 2'b01, 0, "R9");
    // R10: back-to-back faults keep data
    do_req(1, 0, 2'd2, 2'b10, 1, "R10");
    do_req(1, 0, 2'd1, 2'b01, 1, "R10");
    do_req(0, 1, 2'd1, 2'b01, 1, "R10");

    // R1: spacing between two readings
    do_req(1, 0, 2'd0, 2'b01, 0, "R3");
    first = {hi, lo};
    repeat (37) @(negedge clk);
    do_req(1, 0, 2'd0, 2'b01, 0, "R3");
    check({hi, lo} - first == 64'd38, "R1",
          $sformatf("act delta=%0d exp delta=38", {hi, lo} - first));

    // R1: narrow instance steps from all ones to zero
    while (tb_cnt[SCW-1:0] != {SCW{1'b1}}) @(negedge clk);
    do_req(1, 0, 2'd0, 2'b00, 0, "R1");
    check({w_hi, w_lo} == {SCW{1'b1}}, "R1", $sformatf("act %h exp ff", {w_hi, w_lo}));
    do_req(0, 1, 2'd0, 2'b00, 0, "R1");
    check(w_md == '0 && w_msr_v, "R1", $sformatf("act %h exp 00", w_md));

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 2) @(negedge clk);
      else do_req(sel < 8, sel >= 7, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), "R3");
    end

    // R2: reset in the middle of a run
    rst_n = 1'b0;
    @(negedge clk);
    check_reset("R2");
    rst_n = 1'b1;
    @(negedge clk);
    do_req(1, 0, 2'd3, 2'b10, 0, "R2");
    check({hi, lo} == 64'd1, "R2", $sformatf("act %h exp 1", {hi, lo}));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule